// File: doc/BRIEF.md
# SPI Target Port with Transfer Status Flags

This block is the target (slave) end of a four-wire SPI link. A fast system clock oversamples the serial clock, the select line and the incoming data line. The block shifts 8-bit frames and drives the outgoing data line while it is selected. Software reaches it through a small synchronous register port with three registers: mode, status and data.

The mode register picks clock polarity, clock phase and bit order. A byte written to the data register goes straight into the transmit shift path, because there is no transmit buffer. A completed incoming byte lands in a single receive buffer.

Three status conditions are reported. "Frame done" means a byte has arrived. "Overrun" means a byte was lost because the previous one had not been taken. "Collision" means the data register was written while a frame was being shifted. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_target_port`

## Requirements
- R1: After reset the mode register (address 0) reads 0, the status register (address 1) reads 0, and `spi_miso_en` and `spi_miso` are both 0.
- R2: The sampling edge is the rising serial-clock edge when CPOL (mode bit 0) equals CPHA (mode bit 1), and the falling edge otherwise. In all four modes a received byte reads back unchanged from the data register (address 2).
- R3: When mode bit 2 is 1, bits travel least significant first on both data lines. When it is 0, they travel most significant first.
- R4: `spi_miso_en` is 1 exactly while the select line is low, and `spi_miso` is 0 while it is high. The first transmit bit is present from the fall of select, and each frame carries the transmit byte in the configured order.
- R5: Frame done (status bit 0) sets after the eighth sampling edge of a frame, and the byte goes to the receive buffer.
- R6: Frame done clears only when a data-register read or write follows a status read that saw it set. A data access without that prior status read leaves it set.
- R7: When a frame completes while frame done is still set, the new byte is dropped, the receive buffer keeps its old byte and overrun (status bit 1) sets.
- R8: Overrun and collision stay set until a status read, which returns them and then clears them.
- R9: A data-register write between the first leading serial-clock edge of a frame and its completion sets collision (status bit 2) and changes neither the byte being sent nor the byte sent in later frames.
- R10: If select rises before the eighth sampling edge, the partial frame is dropped without setting frame done, and the next frame starts from bit 0.
- R11: With no data write since the previous frame, the next frame sends the same transmit byte again.
- R12: A clearing data access in the same cycle as a frame completion frees the buffer first. The new byte is stored, frame done stays set, overrun stays clear, and the access returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address: 0 mode, 1 status, 2 data |
| reg_rd | input | 1 | Read strobe; `reg_rdata` is valid the next cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | FRAME_W | Write data |
| reg_rdata | output | FRAME_W | Registered read data |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_ssel_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_en | output | 1 | High while `spi_miso` should be driven onto the line |

## Verification
Two events can fall in the same system-clock cycle: completion of a frame and the data-register access that clears frame done. The bench provokes this by counting the synchronizer stages between the final sampling serial-clock edge on the pin and the cycle in which the completion acts, and issuing the clearing data read in exactly that cycle. It then judges the result. The read must return the previous byte. The next status read must show frame done set with overrun clear, and the following data read must return the new byte.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

   // register addresses
   localparam int unsigned REG_MODE = 0;
   localparam int unsigned REG_STAT = 1;
   localparam int unsigned REG_DATA = 2;

   // status bit positions
   localparam int unsigned ST_DONE = 0;
   localparam int unsigned ST_OVR  = 1;
   localparam int unsigned ST_WCOL = 2;

   // mode register layout: bit0 polarity, bit1 phase, bit2 lsb-first
   typedef struct packed {
      logic lsb_first;
      logic cpha;
      logic cpol;
   } spi_mode_t;

   localparam int unsigned MODE_BITS = $bits(spi_mode_t);

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int unsigned           WIDTH   = 3,
   parameter int unsigned           STAGES  = 2,
   parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_tgt_sync: STAGES must be at least 2");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [WIDTH-1:0] r;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= g_stage[s-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
   import spi_tgt_pkg::*;
#(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_s,
   input  logic               ssel_n_s,
   input  logic               mosi_s,
   input  spi_mode_t          mode,
   input  logic               tx_load,
   input  logic [FRAME_W-1:0] tx_data,
   output logic               busy,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_byte,
   output logic               miso,
   output logic               miso_en
);

   localparam int unsigned      CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_W - 1);

   logic               sck_q;
   logic               sel;
   logic               rise, fall;
   logic               samp_edge, lead_edge;
   logic [CNT_W-1:0]   rx_cnt;
   logic [FRAME_W-1:0] rx_acc;
   logic [FRAME_W-1:0] tx_reg;
   logic [CNT_W-1:0]   tx_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign sel  = ~ssel_n_s;
   assign rise = sck_s & ~sck_q;
   assign fall = ~sck_s & sck_q;

   // sampling edge: rising when polarity equals phase
   assign samp_edge = sel & ((mode.cpol ^ mode.cpha) ? fall : rise);
   // leading edge: first edge away from the idle level
   assign lead_edge = sel & (mode.cpol ? fall : rise);

   assign frame_done = samp_edge & (rx_cnt == LAST);
   assign frame_byte = mode.lsb_first ? {mosi_s, rx_acc[FRAME_W-1:1]}
                                      : {rx_acc[FRAME_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_cnt <= '0;
         rx_acc <= '0;
      end else begin
         if (!sel)
            rx_cnt <= '0;
         else if (samp_edge)
            rx_cnt <= (rx_cnt == LAST) ? '0 : rx_cnt + 1'b1;
         if (samp_edge)
            rx_acc <= frame_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (!sel)       busy <= 1'b0;
      else if (frame_done) busy <= 1'b0;
      else if (lead_edge)  busy <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_reg <= '0;
      else if (tx_load) tx_reg <= tx_data;
   end

   // the bit on the line follows the number of samples already taken
   assign tx_idx  = mode.lsb_first ? rx_cnt : LAST - rx_cnt;
   assign miso    = sel & tx_reg[tx_idx];
   assign miso_en = sel;

   AST_TX_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(tx_reg)); // R9

   AST_DESELECT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ssel_n_s |=> (!busy && rx_cnt == '0)); // R10

   AST_DONE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !ssel_n_s); // R5

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
   import spi_tgt_pkg::*;
#(
   parameter int unsigned FRAME_W = 8,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               rd,
   input  logic               wr,
   input  logic [FRAME_W-1:0] wdata,
   input  logic               frame_done,
   input  logic [FRAME_W-1:0] frame_byte,
   input  logic               busy,
   output logic [FRAME_W-1:0] rdata,
   output spi_mode_t          mode,
   output logic               tx_load,
   output logic [FRAME_W-1:0] tx_data
);

   logic               hit_mode, hit_stat, hit_data;
   logic               stat_rd, data_acc;
   logic               done_f, ovr_f, wcol_f, armed;
   logic               clr_done, done_eff;
   logic               accept, ovr_set, wcol_set;
   logic [FRAME_W-1:0] rx_buf;

   assign hit_mode = (addr == ADDR_W'(REG_MODE));
   assign hit_stat = (addr == ADDR_W'(REG_STAT));
   assign hit_data = (addr == ADDR_W'(REG_DATA));

   assign stat_rd  = rd & hit_stat;
   assign data_acc = (rd | wr) & hit_data;

   // a clearing access in the same cycle as a completion frees the buffer first
   assign clr_done = data_acc & armed;
   assign done_eff = done_f & ~clr_done;
   assign accept   = frame_done & ~done_eff;
   assign ovr_set  = frame_done & done_eff;
   assign wcol_set = wr & hit_data & busy;

   assign tx_load  = wr & hit_data & ~busy;
   assign tx_data  = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= '0;
      else if (wr && hit_mode)
         mode <= spi_mode_t'(wdata[MODE_BITS-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_f <= 1'b0;
         armed  <= 1'b0;
         ovr_f  <= 1'b0;
         wcol_f <= 1'b0;
         rx_buf <= '0;
      end else begin
         if (accept)        done_f <= 1'b1;
         else if (clr_done) done_f <= 1'b0;

         if (clr_done)                armed <= 1'b0;
         else if (stat_rd && done_f)  armed <= 1'b1;

         ovr_f  <= (ovr_f  & ~stat_rd) | ovr_set;
         wcol_f <= (wcol_f & ~stat_rd) | wcol_set;

         if (accept) rx_buf <= frame_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         if (hit_mode)
            rdata <= {{(FRAME_W-MODE_BITS){1'b0}}, mode};
         else if (hit_stat)
            rdata <= {{(FRAME_W-3){1'b0}}, wcol_f, ovr_f, done_f};
         else if (hit_data)
            rdata <= rx_buf;
         else
            rdata <= '0;
      end
   end

   AST_DONE_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> done_f); // R5

   AST_UNARMED_KEEPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_f && !armed) |=> done_f); // R6

   AST_OVERRUN_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && done_f && !data_acc) |=> ($stable(rx_buf) && ovr_f)); // R7

   AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !frame_done && !wr) |=> (!ovr_f && !wcol_f)); // R8

   AST_COLLISION_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_data && busy) |=> wcol_f); // R9

endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
   import spi_tgt_pkg::*;
#(
   parameter int unsigned FRAME_W     = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_rd,
   input  logic               reg_wr,
   input  logic [FRAME_W-1:0] reg_wdata,
   output logic [FRAME_W-1:0] reg_rdata,
   input  logic               spi_sck,
   input  logic               spi_ssel_n,
   input  logic               spi_mosi,
   output logic               spi_miso,
   output logic               spi_miso_en
);

   generate
      if (FRAME_W < 4 || FRAME_W > 32) begin : g_bad_frame
         $error("spi_target_port: FRAME_W must lie in 4..32");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("spi_target_port: ADDR_W must be at least 2");
      end
   endgenerate

   logic [2:0]         pins_s;
   logic               busy;
   logic               frame_done;
   logic [FRAME_W-1:0] frame_byte;
   logic               tx_load;
   logic [FRAME_W-1:0] tx_data;
   spi_mode_t          mode;

   // select idles high, clock and data idle low
   spi_tgt_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_mosi, spi_ssel_n, spi_sck}),
      .q     (pins_s)
   );

   spi_tgt_shift #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (pins_s[0]),
      .ssel_n_s   (pins_s[1]),
      .mosi_s     (pins_s[2]),
      .mode       (mode),
      .tx_load    (tx_load),
      .tx_data    (tx_data),
      .busy       (busy),
      .frame_done (frame_done),
      .frame_byte (frame_byte),
      .miso       (spi_miso),
      .miso_en    (spi_miso_en)
   );

   spi_tgt_regs #(
      .FRAME_W (FRAME_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (reg_addr),
      .rd         (reg_rd),
      .wr         (reg_wr),
      .wdata      (reg_wdata),
      .frame_done (frame_done),
      .frame_byte (frame_byte),
      .busy       (busy),
      .rdata      (reg_rdata),
      .mode       (mode),
      .tx_load    (tx_load),
      .tx_data    (tx_data)
   );

   AST_MISO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_miso_en |-> !spi_miso); // R4

endmodule

// File: tb/spi_target_port_tb.sv
`timescale 1ns/1ps
module spi_target_port_tb;

   localparam int HALF = 6;
   localparam logic [1:0] A_MODE = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_rd = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       spi_sck = 1'b0;
   logic       spi_ssel_n = 1'b1;
   logic       spi_mosi = 1'b0;
   logic       spi_miso;
   logic       spi_miso_en;

   int   checks = 0;
   int   fails  = 0;
   logic cur_cpol = 1'b0, cur_cpha = 1'b0, cur_lsb = 1'b0;
   logic [7:0] exp_tx = '0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   spi_target_port u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_addr    (reg_addr),
      .reg_rd      (reg_rd),
      .reg_wr      (reg_wr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .spi_sck     (spi_sck),
      .spi_ssel_n  (spi_ssel_n),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_en (spi_miso_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
   endtask

   task automatic set_mode(input logic pol, input logic pha, input logic lsb);
      reg_write(A_MODE, {5'b0, lsb, pha, pol});
      cur_cpol = pol; cur_cpha = pha; cur_lsb = lsb;
      spi_sck = pol;
      repeat (4) @(negedge clk);
   endtask

   task automatic load_tx(input logic [7:0] d);
      reg_write(A_DATA, d);
      exp_tx = d;
   endtask

   // data read placed in the cycle where the last sample edge takes effect
   task automatic clash_read(output logic [7:0] v);
      @(negedge clk);
      @(negedge clk); reg_addr = A_DATA; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
      repeat (HALF - 3) @(negedge clk);
   endtask

   // driver: pushes the expected MISO byte, then plays one frame on the pins
   task automatic frame(input logic [7:0] mo, input int nbits, input bit wcol_at,
                        input bit clr_at, output logic [7:0] clr_val);
      logic first;
      clr_val = '0;
      if (nbits == 8) exp_q.push_back(exp_tx);
      first = cur_lsb ? exp_tx[0] : exp_tx[7];
      @(negedge clk); spi_sck = cur_cpol; spi_ssel_n = 1'b0;
      repeat (HALF) @(negedge clk);
      chk(spi_miso_en && spi_miso == first, "R4 first bit at select",
          {spi_miso_en, spi_miso}, {1'b1, first});
      for (int i = 0; i < nbits; i++) begin
         logic b;
         logic last;
         b    = cur_lsb ? mo[i] : mo[7-i];
         last = (i == 7) && clr_at;
         if (!cur_cpha) begin
            spi_mosi = b;
            repeat (HALF) @(negedge clk);
            spi_sck = ~cur_cpol;
            if (last) clash_read(clr_val); else repeat (HALF) @(negedge clk);
            spi_sck = cur_cpol;
         end else begin
            spi_sck = ~cur_cpol; spi_mosi = b;
            repeat (HALF) @(negedge clk);
            spi_sck = cur_cpol;
            if (last) clash_read(clr_val); else repeat (HALF) @(negedge clk);
         end
         if (wcol_at && i == 3) reg_write(A_DATA, 8'hFF);
      end
      repeat (HALF) @(negedge clk);
      spi_ssel_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   // monitor: rebuilds the MISO byte at the bench's own sampling edges
   initial begin
      int nb;
      logic [7:0] acc;
      logic [7:0] e;
      nb = 0; acc = '0;
      forever begin
         @(spi_sck or posedge spi_ssel_n);
         if (spi_ssel_n) begin
            nb = 0;
         end else if (spi_sck == !(cur_cpol ^ cur_cpha)) begin
            if (cur_lsb) acc[nb] = spi_miso; else acc[7-nb] = spi_miso;
            nb++;
            if (nb == 8) begin
               nb = 0;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4 unexpected frame", acc, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(acc == e, "R4 R11 MISO byte", acc, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] cv;
      logic [7:0] mo;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      chk(!spi_miso_en && !spi_miso, "R1 miso idle", {spi_miso_en, spi_miso}, 0);
      reg_read(A_MODE, v); chk(v == 8'h00, "R1 mode reg", v, 8'h00);
      reg_read(A_STAT, v); chk(v == 8'h00, "R1 status reg", v, 8'h00);

      // R2 all four modes, msb first
      for (int m = 0; m < 4; m++) begin
         set_mode(m[0], m[1], 1'b0);
         load_tx(8'hA5 ^ (8'(m) * 8'h11));
         mo = 8'h3C + 8'(m) * 8'h21;
         frame(mo, 8, 1'b0, 1'b0, cv);
         reg_read(A_STAT, v); chk(v == 8'h01, "R5 done set", v, 8'h01);
         reg_read(A_DATA, v); chk(v == mo, "R2 rx byte", v, mo);
         reg_read(A_STAT, v); chk(v == 8'h00, "R6 done cleared", v, 8'h00);
         chk(!spi_miso_en && !spi_miso, "R4 deselected quiet", {spi_miso_en, spi_miso}, 0);
      end

      // R3 lsb first in modes 0 and 3
      set_mode(1'b0, 1'b0, 1'b1);
      load_tx(8'h81);
      frame(8'h4E, 8, 1'b0, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h01, "R3 done", v, 8'h01);
      reg_read(A_DATA, v); chk(v == 8'h4E, "R3 rx lsb mode0", v, 8'h4E);
      set_mode(1'b1, 1'b1, 1'b1);
      load_tx(8'h0D);
      frame(8'hB1, 8, 1'b0, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h01, "R3 done", v, 8'h01);
      reg_read(A_DATA, v); chk(v == 8'hB1, "R3 rx lsb mode3", v, 8'hB1);

      // R6 data access without a prior status read does not clear
      set_mode(1'b0, 1'b0, 1'b0);
      load_tx(8'h5A);
      frame(8'hC3, 8, 1'b0, 1'b0, cv);
      reg_read(A_DATA, v); chk(v == 8'hC3, "R6 rx byte", v, 8'hC3);
      reg_read(A_STAT, v); chk(v == 8'h01, "R6 done still set", v, 8'h01);
      load_tx(8'h96);
      reg_read(A_STAT, v); chk(v == 8'h00, "R6 write clears", v, 8'h00);

      // R7 overrun, R11 retransmit of 0x96 in both frames
      frame(8'h11, 8, 1'b0, 1'b0, cv);
      frame(8'h22, 8, 1'b0, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h03, "R7 overrun flagged", v, 8'h03);
      reg_read(A_DATA, v); chk(v == 8'h11, "R7 old byte kept", v, 8'h11);
      reg_read(A_STAT, v); chk(v == 8'h00, "R8 overrun cleared", v, 8'h00);

      // R9 collision during a frame
      load_tx(8'h3C);
      frame(8'h77, 8, 1'b1, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h05, "R9 collision flagged", v, 8'h05);
      reg_read(A_STAT, v); chk(v == 8'h01, "R8 collision cleared", v, 8'h01);
      reg_read(A_DATA, v); chk(v == 8'h77, "R9 rx unaffected", v, 8'h77);
      frame(8'h00, 8, 1'b0, 1'b0, cv); // R9 R11 still sends 0x3C
      reg_read(A_STAT, v); chk(v == 8'h01, "R11 done", v, 8'h01);
      reg_read(A_DATA, v); chk(v == 8'h00, "R11 rx byte", v, 8'h00);

      // R10 aborted frame
      frame(8'hF0, 3, 1'b0, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h00, "R10 no done after abort", v, 8'h00);
      frame(8'h6B, 8, 1'b0, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h01, "R10 next frame done", v, 8'h01);
      reg_read(A_DATA, v); chk(v == 8'h6B, "R10 next frame fresh", v, 8'h6B);

      // R12 clearing read coincides with completion
      set_mode(1'b0, 1'b1, 1'b0);
      frame(8'hD2, 8, 1'b0, 1'b0, cv);
      reg_read(A_STAT, v); chk(v == 8'h01, "R12 armed", v, 8'h01);
      frame(8'h2D, 8, 1'b0, 1'b1, cv);
      chk(cv == 8'hD2, "R12 clash read old byte", cv, 8'hD2);
      reg_read(A_STAT, v); chk(v == 8'h01, "R12 done kept no overrun", v, 8'h01);
      reg_read(A_DATA, v); chk(v == 8'h2D, "R12 new byte stored", v, 8'h2D);
      reg_read(A_STAT, v); chk(v == 8'h00, "R12 cleared", v, 8'h00);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule